// File: doc/BRIEF.md
# Video Control Signal Glitch Filter

This block conditions the three slow video control signals (data enable, horizontal sync and vertical sync) in the pixel-clock domain. They pass through it before a serializer packs them into its stream. Short spikes on these lines would disturb the picture. The filter therefore delays each signal, checks how long a new level has lasted, and limits how often each output may change.

Data enable and horizontal sync share one rule set. Each gets a three-stage sample line, so any edge reaches the output three clocks later. When the filter-enable input is high, a new level is forwarded only once it has filled the whole sample line. Each of these outputs may change at most twice inside a 130-clock window, and every accepted change restarts that window. Vertical sync has a stricter rule. Its level must hold for 130 samples before it is forwarded, and it may change only once per 130 clocks.

If a change meets its width rule while its budget is spent, the output keeps its level. Once the window runs out, the output takes whatever qualified level is present at that moment. Glitches that fail the width rule never reach the output and do not consume budget.

Top module: `vctl_filter`

## Requirements
- R1: A synchronous reset drives all three outputs low and marks every window as expired, so the first qualified change after reset is accepted with no extra wait.
- R2: A level on de_i or hs_i that is sampled at clock edge k appears on the output after edge k+3. This delay is the same with flt_en high or low, and both outputs stay aligned with each other.
- R3: With flt_en high, a new de_i or hs_i level is forwarded only if it is sampled on 3 consecutive edges. Pulses of 1 or 2 clocks are discarded.
- R4: With flt_en low, de_i and hs_i have no width check, and a single-clock pulse is forwarded.
- R5: de_o and hs_o each change at most twice per window. The window is 130 clocks long and restarts at every accepted change. A third change waits until 130 clocks after the most recent accepted change.
- R6: A qualified change that is held back by R5 or R9 is applied on the first edge at which the window has expired, provided the qualified level still differs from the output.
- R7: Transitions rejected by a width rule consume no budget. After three rejected glitches, a valid rise and fall still both pass within one window.
- R8: A vs_i level is forwarded only after it is sampled on 130 consecutive edges. A level first sampled at edge k appears after edge k+130. Shorter pulses are discarded, whatever the state of flt_en.
- R9: vs_o changes at most once per 130 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_en | input | 1 | Enables the 3-clock width check on de_i and hs_i |
| de_i | input | 1 | Raw data enable |
| hs_i | input | 1 | Raw horizontal sync |
| vs_i | input | 1 | Raw vertical sync |
| de_o | output | 1 | Filtered data enable |
| hs_o | output | 1 | Filtered horizontal sync |
| vs_o | output | 1 | Filtered vertical sync |

## Verification
The source-level checks trace every output change back to the raw input samples a fixed number of edges earlier. They therefore assume that inputs are sampled cleanly on the rising edge and that flt_en does not change between the samples of one edge. The bench changes every input, flt_en included, only on the falling clock edge. It also applies a reset before each table entry, so no earlier window or sample history leaks into an entry. The spacing checks assume no history before reset; the bench holds all inputs low while reset is asserted.

// File: rtl/vctl_filter.sv
module vctl_filter #(
  parameter int WIN     = 130,
  parameter int FAST_BUD = 2,
  parameter int VS_BUD  = 1,
  parameter int MINW    = 3,
  parameter int VS_HOLD = 130
) (
  input  logic clk,
  input  logic rst,
  input  logic flt_en,
  input  logic de_i,
  input  logic hs_i,
  input  logic vs_i,
  output logic de_o,
  output logic hs_o,
  output logic vs_o
);
  localparam int WW = $clog2(WIN + 1);
  localparam int TW = $clog2(FAST_BUD + VS_BUD + 1);
  localparam int HW = $clog2(VS_HOLD + 1);

  logic [2:0] raw, prop, outq;
  assign raw = {vs_i, hs_i, de_i};

  for (genvar i = 0; i < 2; i++) begin : g_fast
    logic [MINW-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[MINW-2:0], raw[i]};
    end
    assign prop[i] = !flt_en ? sr[MINW-1] :
                     (&sr)   ? 1'b1 :
                     (~|sr)  ? 1'b0 : outq[i];
  end

  logic          vs_q;
  logic [HW-1:0] vs_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q   <= 1'b0;
      vs_run <= '0;
    end else begin
      vs_q <= vs_i;
      if (vs_i != vs_q)               vs_run <= HW'(1);
      else if (vs_run < HW'(VS_HOLD)) vs_run <= vs_run + 1'b1;
    end
  end
  assign prop[2] = (vs_run >= HW'(VS_HOLD)) ? vs_q : outq[2];

  for (genvar i = 0; i < 3; i++) begin : g_bud
    localparam int BUD = (i == 2) ? VS_BUD : FAST_BUD;
    logic [WW-1:0] win;
    logic [TW-1:0] tr;
    logic          expired, accept;
    assign expired = (win == WW'(WIN));
    assign accept  = (prop[i] != outq[i]) && (expired || tr < TW'(BUD));
    always_ff @(posedge clk) begin
      if (rst) begin
        win     <= WW'(WIN);
        tr      <= '0;
        outq[i] <= 1'b0;
      end else if (accept) begin
        win     <= WW'(1);
        tr      <= expired ? TW'(1) : tr + 1'b1;
        outq[i] <= prop[i];
      end else if (!expired) begin
        win <= win + 1'b1;
      end
    end
  end

  assign de_o = outq[0];
  assign hs_o = outq[1];
  assign vs_o = outq[2];
endmodule

// File: rtl/vctl_filter_chk.sv
module vctl_filter_chk #(
  parameter int WIN = 130
) (
  input logic clk,
  input logic rst,
  input logic flt_en,
  input logic de_i,
  input logic hs_i,
  input logic vs_i,
  input logic de_o,
  input logic hs_o,
  input logic vs_o
);
  localparam int GW = $clog2(WIN + 2);
  logic [2:0] oq, chg;
  logic [GW-1:0] g_last [3];
  logic [GW-1:0] g_prev [3];

  assign chg = {vs_o, hs_o, de_o} ^ oq;

  function automatic logic [GW-1:0] sat_inc(input logic [GW-1:0] v);
    return (v >= GW'(WIN)) ? GW'(WIN) : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      oq <= '0;
      for (int i = 0; i < 3; i++) begin
        g_last[i] <= GW'(WIN);
        g_prev[i] <= GW'(WIN);
      end
    end else begin
      oq <= {vs_o, hs_o, de_o};
      for (int i = 0; i < 3; i++) begin
        if (chg[i]) begin
          g_prev[i] <= sat_inc(g_last[i]);
          g_last[i] <= GW'(1);
        end else begin
          g_prev[i] <= sat_inc(g_prev[i]);
          g_last[i] <= sat_inc(g_last[i]);
        end
      end
    end
  end

  AST_DE_SOURCE: assert property (@(posedge clk) disable iff (rst) chg[0] |-> $past(de_i, 4) == de_o); // R2
  AST_HS_SOURCE: assert property (@(posedge clk) disable iff (rst) chg[1] |-> $past(hs_i, 4) == hs_o); // R2
  AST_DE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (chg[0] && $past(flt_en)) |-> ($past(de_i, 2) == de_o && $past(de_i, 3) == de_o)); // R3
  AST_HS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (chg[1] && $past(flt_en)) |-> ($past(hs_i, 2) == hs_o && $past(hs_i, 3) == hs_o)); // R3
  AST_DE_BUDGET: assert property (@(posedge clk) disable iff (rst) chg[0] |-> g_prev[0] >= GW'(WIN)); // R5
  AST_HS_BUDGET: assert property (@(posedge clk) disable iff (rst) chg[1] |-> g_prev[1] >= GW'(WIN)); // R5
  AST_VS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    chg[2] |-> ($past(vs_i, 2) == vs_o && $past(vs_i, 3) == vs_o)); // R8
  AST_VS_SPACING: assert property (@(posedge clk) disable iff (rst) chg[2] |-> g_last[2] >= GW'(WIN)); // R9
endmodule

bind vctl_filter vctl_filter_chk #(.WIN(WIN)) u_chk (.*);

// File: tb/vctl_filter_tb.sv
module vctl_filter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flt_en = 1'b0;
  logic de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
  logic de_o, hs_o, vs_o;
  int checks = 0;
  int errors = 0;

  vctl_filter u_dut (.clk(clk), .rst(rst), .flt_en(flt_en), .de_i(de_i), .hs_i(hs_i),
                     .vs_i(vs_i), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o));

  always #2 clk = ~clk;

  // [15] expect pass, [14] flt_en, [13:12] channel 0=DE 1=HS 2=VS, [11:0] pulse width
  localparam logic [15:0] VEC [12] = '{
    {1'b0, 1'b1, 2'd0, 12'd1},   {1'b0, 1'b1, 2'd0, 12'd2},
    {1'b1, 1'b1, 2'd0, 12'd3},   {1'b1, 1'b1, 2'd0, 12'd5},
    {1'b1, 1'b0, 2'd0, 12'd1},   {1'b0, 1'b1, 2'd1, 12'd2},
    {1'b1, 1'b1, 2'd1, 12'd3},   {1'b1, 1'b0, 2'd1, 12'd2},
    {1'b0, 1'b1, 2'd2, 12'd129}, {1'b1, 1'b1, 2'd2, 12'd130},
    {1'b0, 1'b0, 2'd2, 12'd129}, {1'b1, 1'b0, 2'd2, 12'd200}
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; de_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic set_ch(input int ch, input logic v);
    if (ch == 0) de_i = v;
    else if (ch == 1) hs_i = v;
    else vs_i = v;
  endtask

  function automatic logic get_ch(input int ch);
    return (ch == 0) ? de_o : (ch == 1) ? hs_o : vs_o;
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int v = 0; v < 12; v++) begin
      int ch, w;
      logic seen;
      string req;
      ch = int'(VEC[v][13:12]);
      w = int'(VEC[v][11:0]);
      req = (ch == 2) ? "R8" : VEC[v][14] ? "R3" : "R4";
      do_reset();
      flt_en = VEC[v][14];
      seen = 1'b0;
      set_ch(ch, 1'b1);
      for (int i = 0; i < w + 300; i++) begin
        if (i == w) set_ch(ch, 1'b0);
        tick(1);
        seen |= get_ch(ch);
      end
      check(req, seen, VEC[v][15]);
    end

    // R1: reset state and first change accepted at once; R2 latency and alignment
    flt_en = 1'b1;
    do_reset();
    check("R1 de", de_o, 1'b0);
    check("R1 hs", hs_o, 1'b0);
    check("R1 vs", vs_o, 1'b0);
    de_i = 1'b1; hs_i = 1'b1;
    tick(3);
    check("R2 de early", de_o, 1'b0);
    tick(1);
    check("R2 R1 de", de_o, 1'b1);
    check("R2 hs aligned", hs_o, 1'b1);
    flt_en = 1'b0;
    do_reset();
    de_i = 1'b1;
    tick(3);
    check("R2 off early", de_o, 1'b0);
    tick(1);
    check("R2 off", de_o, 1'b1);

    // R5 budget and R6 deferred change
    do_reset();
    de_i = 1'b1; tick(10);
    de_i = 1'b0; tick(10);
    de_i = 1'b1; tick(120);
    check("R5 third blocked", de_o, 1'b0);
    tick(3);
    check("R5 still blocked", de_o, 1'b0);
    tick(1);
    check("R6 deferred applied", de_o, 1'b1);

    // R7 rejected glitches consume no budget
    flt_en = 1'b1;
    do_reset();
    for (int g = 0; g < 3; g++) begin
      hs_i = 1'b1; tick(1);
      hs_i = 1'b0; tick(2);
    end
    tick(3);
    check("R7 glitches dropped", hs_o, 1'b0);
    hs_i = 1'b1; tick(4);
    check("R7 rise passes", hs_o, 1'b1);
    hs_i = 1'b0; tick(4);
    check("R7 fall passes", hs_o, 1'b0);

    // R8 latency and R9 spacing on VS
    do_reset();
    vs_i = 1'b1;
    tick(130);
    check("R8 vs early", vs_o, 1'b0);
    vs_i = 1'b0;
    tick(1);
    check("R8 vs rise", vs_o, 1'b1);
    tick(129);
    check("R9 vs held", vs_o, 1'b1);
    tick(1);
    check("R9 vs fall", vs_o, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule